// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit executes one packed-integer operation on two 64-bit operands per accepted request. Each operand is split into equal lanes of 8, 16, 32 or 64 bits, and every lane is processed on its own: no carry, borrow or shifted bit crosses from one lane into the next. The unit adds and subtracts with either wrap-around or clamping arithmetic, compares lanes into all-ones/all-zeros masks, multiplies four signed 16-bit lanes and keeps either half of each product, and shifts lanes left or right, logically or arithmetically.

A request is presented with `valid_i` together with the opcode, lane size, saturation mode and both operands. The result is registered and appears one clock later with `valid_o`. Between requests the last result stays on `result_o`. Operand fetch, instruction decode and lane packing or unpacking belong to the surrounding datapath.

Top module: `simd_alu`

## Requirements
- R1: With `sat_i` 0 or 3 (wrap), ADD (`op_i`=0) and SUB (`op_i`=1) produce each lane modulo 2^W, where W is 8, 16, 32 or 64 for `lane_i` 0, 1, 2, 3; lane i occupies bits [i*W +: W] and no carry or borrow reaches a neighbouring lane.
- R2: With `sat_i`=1 (signed clamp), an ADD or SUB lane whose two's-complement result overflows returns 0x7F..F, and one that underflows returns 0x80..0.
- R3: With `sat_i`=2 (unsigned clamp), an ADD lane that carries out returns all-ones and a SUB lane that borrows returns zero.
- R4: CMPEQ (`op_i`=2) and signed CMPGT (`op_i`=3) write all-ones to a lane when the condition holds and all-zeros otherwise.
- R5: MULLO (`op_i`=4) and MULHI (`op_i`=5) multiply four signed 16-bit lanes and return bits [15:0] or [31:16] of each 32-bit product; `lane_i` and `sat_i` have no effect on them.
- R6: SLL (`op_i`=6), SRL (`op_i`=7) and SRA (`op_i`=8) shift every lane by the unsigned count held in the full 64 bits of `b_i`; SRA fills with the lane's sign bit.
- R7: A shift count at or above the lane width yields zero for SLL and SRL and a full copy of the sign bit for SRA.
- R8: `valid_o` equals `valid_i` of the previous cycle; `result_o` takes the new result on a cycle with `valid_i` high and otherwise holds its value.
- R9: While `rst_ni` is low, `result_o` and `valid_o` are zero.
- R10: Opcodes 9 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| lane_i | input | 2 | Lane size: 0 byte, 1 halfword, 2 word, 3 quadword |
| sat_i | input | 2 | 0/3 wrap, 1 signed clamp, 2 unsigned clamp |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand or shift count |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result strobe |

## Verification
The embedded properties check on every cycle that the result strobe trails the request by exactly one clock, that the result holds between requests, that every byte of a compare result is 0x00 or 0xFF, and that unsigned-clamped byte additions never fall below and subtractions never rise above the first operand. The exact lane values, including lane isolation of carries, signed clamping to the extreme codes, product halves, shift fills for oversized counts and zero output for unused opcodes, are shown only by the bench's vector table and its directed cases.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMPEQ = 4'd2,
    OP_CMPGT = 4'd3,
    OP_MULLO = 4'd4,
    OP_MULHI = 4'd5,
    OP_SLL   = 4'd6,
    OP_SRL   = 4'd7,
    OP_SRA   = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_WRAP_ALT = 2'd3
  } sat_e;

  localparam int unsigned NUM_LANE_SZ = 4;
  localparam int unsigned MIN_LANE_W  = 8;
  localparam int unsigned MUL_LANE_W  = 16;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  op_e               op_i,
  input  sat_e              sat_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;
  localparam int unsigned SH_W      = $clog2(LANE_W);
  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  // shift count is shared by all lanes
  logic              cnt_big;
  logic [SH_W-1:0]   sh_amt;
  assign cnt_big = (b_i >= DATA_W'(LANE_W));
  assign sh_amt  = b_i[SH_W-1:0];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] x, y, lane_res, add_r, sub_r;
    logic [LANE_W:0]   sum, dif;
    logic              s_ovf_add, s_ovf_sub;

    assign x = a_i[l*LANE_W +: LANE_W];
    assign y = b_i[l*LANE_W +: LANE_W];

    always_comb begin
      sum       = {1'b0, x} + {1'b0, y};
      dif       = {1'b0, x} - {1'b0, y};
      s_ovf_add = (x[LANE_W-1] == y[LANE_W-1]) && (sum[LANE_W-1] != x[LANE_W-1]);
      s_ovf_sub = (x[LANE_W-1] != y[LANE_W-1]) && (dif[LANE_W-1] != x[LANE_W-1]);
      add_r     = sum[LANE_W-1:0];
      sub_r     = dif[LANE_W-1:0];
      if (sat_i == SAT_SIGNED) begin
        if (s_ovf_add) add_r = x[LANE_W-1] ? S_MIN : S_MAX;
        if (s_ovf_sub) sub_r = x[LANE_W-1] ? S_MIN : S_MAX;
      end else if (sat_i == SAT_UNSIGNED) begin
        if (sum[LANE_W]) add_r = '1;
        if (dif[LANE_W]) sub_r = '0;
      end

      unique case (op_i)
        OP_ADD:   lane_res = add_r;
        OP_SUB:   lane_res = sub_r;
        OP_CMPEQ: lane_res = (x == y) ? '1 : '0;
        OP_CMPGT: lane_res = ($signed(x) > $signed(y)) ? '1 : '0;
        OP_SLL:   lane_res = cnt_big ? '0 : (x << sh_amt);
        OP_SRL:   lane_res = cnt_big ? '0 : (x >> sh_amt);
        OP_SRA:   lane_res = cnt_big ? {LANE_W{x[LANE_W-1]}}
                                     : LANE_W'($signed(x) >>> sh_amt);
        default:  lane_res = '0;
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = lane_res;
  end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              hi_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NUM_LANES = DATA_W / MUL_LANE_W;
  localparam int unsigned PROD_W    = 2 * MUL_LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] prod;
    assign prod = $signed(a_i[l*MUL_LANE_W +: MUL_LANE_W]) *
                  $signed(b_i[l*MUL_LANE_W +: MUL_LANE_W]);
    assign res_o[l*MUL_LANE_W +: MUL_LANE_W] =
      hi_i ? prod[PROD_W-1:MUL_LANE_W] : prod[MUL_LANE_W-1:0];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int unsigned NUM_BYTES = DATA_W / MIN_LANE_W;

  op_e  op;
  sat_e sat;
  assign op  = op_e'(op_i);
  assign sat = sat_e'(sat_i);

  logic [DATA_W-1:0] arith_res [NUM_LANE_SZ];
  logic [DATA_W-1:0] mul_res;
  logic [DATA_W-1:0] nxt_res;

  for (genvar g = 0; g < NUM_LANE_SZ; g++) begin : g_sz
    simd_lane_arith #(
      .DATA_W(DATA_W),
      .LANE_W(MIN_LANE_W << g)
    ) i_arith (
      .a_i  (a_i),
      .b_i  (b_i),
      .op_i (op),
      .sat_i(sat),
      .res_o(arith_res[g])
    );
  end

  simd_mul16 #(.DATA_W(DATA_W)) i_mul (
    .a_i  (a_i),
    .b_i  (b_i),
    .hi_i (op == OP_MULHI),
    .res_o(mul_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_CMPEQ, OP_CMPGT,
      OP_SLL, OP_SRL, OP_SRA: nxt_res = arith_res[lane_i];
      OP_MULLO, OP_MULHI:     nxt_res = mul_res;
      default:                nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt_res;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing"); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("spurious valid_o"); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)) else $error("result changed while idle"); // R8

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chk
    AST_CMP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (op_i == 4'(OP_CMPEQ) || op_i == 4'(OP_CMPGT))) |=>
      (result_o[k*8 +: 8] == 8'h00 || result_o[k*8 +: 8] == 8'hFF))
      else $error("compare byte not a mask"); // R4
    AST_USAT_ADD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == 4'(OP_ADD) && lane_i == 2'd0 && sat_i == 2'(SAT_UNSIGNED)) |=>
      (result_o[k*8 +: 8] >= $past(a_i[k*8 +: 8])))
      else $error("unsigned clamped add wrapped"); // R3
    AST_USAT_SUB_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == 4'(OP_SUB) && lane_i == 2'd0 && sat_i == 2'(SAT_UNSIGNED)) |=>
      (result_o[k*8 +: 8] <= $past(a_i[k*8 +: 8])))
      else $error("unsigned clamped sub wrapped"); // R3
  end
endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;
  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic [1:0]  lane;
    logic [1:0]  sat;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{"R1 ", 4'd0, 2'd0, 2'd0, 64'h01FF_7F80_0102_0304, 64'h0101_0180_FF01_0101, 64'h0200_8000_0003_0405},
    '{"R2 ", 4'd0, 2'd0, 2'd1, 64'h01FF_7F80_0102_0304, 64'h0101_0180_FF01_0101, 64'h0200_7F80_0003_0405},
    '{"R3 ", 4'd0, 2'd0, 2'd2, 64'h01FF_7F80_0102_0304, 64'h0101_0180_FF01_0101, 64'h02FF_80FF_FF03_0405},
    '{"R1 ", 4'd1, 2'd1, 2'd0, 64'h0000_8000_1234_7FFF, 64'h0001_0001_0234_FFFF, 64'hFFFF_7FFF_1000_8000},
    '{"R2 ", 4'd1, 2'd1, 2'd1, 64'h0000_8000_1234_7FFF, 64'h0001_0001_0234_FFFF, 64'hFFFF_8000_1000_7FFF},
    '{"R3 ", 4'd1, 2'd1, 2'd2, 64'h0000_8000_1234_7FFF, 64'h0001_0001_0234_FFFF, 64'h0000_7FFF_1000_0000},
    '{"R1 ", 4'd0, 2'd2, 2'd0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0000},
    '{"R2 ", 4'd0, 2'd3, 2'd1, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 64'h7FFF_FFFF_FFFF_FFFF},
    '{"R1 ", 4'd0, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'h0000_0000_0000_0000},
    '{"R4 ", 4'd2, 2'd0, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00},
    '{"R4 ", 4'd3, 2'd1, 2'd0, 64'h0001_8000_7FFF_0005, 64'h0000_7FFF_8000_0005, 64'hFFFF_0000_FFFF_0000},
    '{"R4 ", 4'd3, 2'd2, 2'd0, 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF},
    '{"R5 ", 4'd4, 2'd0, 2'd1, 64'h0003_FFFF_0100_7FFF, 64'h0004_0002_0100_7FFF, 64'h000C_FFFE_0000_0001},
    '{"R5 ", 4'd5, 2'd3, 2'd2, 64'h0003_FFFF_0100_7FFF, 64'h0004_0002_0100_7FFF, 64'h0000_FFFF_0001_3FFF},
    '{"R6 ", 4'd6, 2'd1, 2'd0, 64'h1234_8001_00FF_F00F, 64'd4,                  64'h2340_0010_0FF0_00F0},
    '{"R6 ", 4'd7, 2'd1, 2'd0, 64'h1234_8001_00FF_F00F, 64'd4,                  64'h0123_0800_000F_0F00},
    '{"R6 ", 4'd8, 2'd1, 2'd0, 64'h1234_8001_00FF_F00F, 64'd4,                  64'h0123_F800_000F_FF00},
    '{"R6 ", 4'd6, 2'd0, 2'd0, 64'h0102_0408_1020_4080, 64'd3,                  64'h0810_2040_8000_0000},
    '{"R6 ", 4'd7, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'd63,                 64'h0000_0000_0000_0001},
    '{"R7 ", 4'd8, 2'd1, 2'd0, 64'h1234_8001_00FF_F00F, 64'd16,                 64'h0000_FFFF_0000_FFFF},
    '{"R7 ", 4'd6, 2'd1, 2'd0, 64'h1234_8001_00FF_F00F, 64'd16,                 64'h0000_0000_0000_0000},
    '{"R7 ", 4'd7, 2'd2, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000},
    '{"R7 ", 4'd8, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'd64,                 64'hFFFF_FFFF_FFFF_FFFF},
    '{"R10", 4'd15, 2'd0, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  lane_i = '0;
  logic [1:0]  sat_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_alu i_simd_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .lane_i(lane_i), .sat_i(sat_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #5;
    check("R9", {valid_o, result_o}, '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R9", {valid_o, result_o}, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      op_i = VEC[i].op; lane_i = VEC[i].lane; sat_i = VEC[i].sat;
      a_i = VEC[i].a; b_i = VEC[i].b;
      @(negedge clk_i);
      check(string'(VEC[i].tag), result_o, VEC[i].exp);
      check("R8", 64'(valid_o), 64'd1);
    end

    // R8: idle cycles keep the last result, operands ignored
    valid_i = 1'b0;
    op_i = 4'd0; lane_i = 2'd0; sat_i = 2'd0;
    a_i = 64'h0101_0101_0101_0101; b_i = a_i;
    @(negedge clk_i);
    check("R8", 64'(valid_o), 64'd0);
    check("R8", result_o, 64'h0000_0000_0000_0000);
    @(negedge clk_i);
    check("R8", result_o, 64'h0000_0000_0000_0000);
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R8", result_o, 64'h0202_0202_0202_0202);

    // R5: lane and saturation selects do not alter a multiply
    op_i = 4'd4; lane_i = 2'd3; sat_i = 2'd1;
    a_i = 64'h0003_FFFF_0100_7FFF; b_i = 64'h0004_0002_0100_7FFF;
    @(negedge clk_i);
    check("R5", result_o, 64'h000C_FFFE_0000_0001);

    // R9: asynchronous reset clears mid-run
    #3 rst_ni = 1'b0;
    #1 check("R9", {valid_o, result_o}, '0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule